// File: doc/BRIEF.md
# Power-Down and Wake-Up Controller

This block sequences a small processor core into and out of its low-power halt state. The core raises a halt strobe when it executes its halt instruction. The controller then drops the system-clock enable and holds the core frozen, with every register and memory word kept as it was. It raises the enable again when a wake source arrives. Two status flags record how the core last stopped or restarted. The power-down flag is set by halt. The time-out flag is set by a watchdog overflow. Software reads both flags after restart to learn the wake cause.

All logic runs on one always-running clock, `clk`. That is the tick domain that keeps toggling while the core's clock is gated. The watchdog counter is part of the block and has a selectable count source. In the internal-oscillator mode it advances on `wdt_tick_i` strobes, and those strobes can be switched off through a configuration input. In the system-clock mode it advances on every `clk` cycle while the system clock is enabled. Port pins pass through a two-stage synchronizer, and a falling edge is found by comparing the newest synchronized sample with the one before it.

The state machine has five states:
- **RUN**: the core is clocked.
- **HALT**: the clock is gated.
- **RESUME**: a one-cycle continue pulse.
- **PRST**: a one-cycle pulse that resets only the program counter and stack pointer.
- **FRST**: a one-cycle full-reset pulse.

Its transitions are:
- RUN→HALT on an accepted halt strobe.
- RUN or HALT→PRST on a watchdog overflow.
- HALT→RESUME on an enabled port falling edge or an interrupt.
- Any state→FRST on external reset.
- RESUME, PRST and FRST→RUN after one cycle.

Top module: `pwrdn_wake_ctrl`

## Requirements
- R1: The only way into HALT is `halt_i` while in RUN. `sys_clk_en_o` is 0 exactly while in HALT. It stays 0 until a wake source is accepted.
- R2: An accepted halt sets `pdf_o` to 1 and clears `to_o` to 0 on the next cycle.
- R3: Power-on reset (`rst_n` low) clears both flags. `clrwdt_i` in RUN, when no halt, overflow or external reset is present, clears `pdf_o` and clears the watchdog counter.
- R4: With `cfg_wdt_src_sys_i`=0, an accepted halt clears the counter (`wdt_clr_o`=1), and counting continues on ticks during HALT. With `cfg_wdt_src_sys_i`=1, `wdt_run_o` is 0 in HALT and the counter is frozen.
- R5: With `cfg_wdt_src_sys_i`=0 and `cfg_wdt_osc_en_i`=0, `wdt_run_o` is 0, the counter never advances, and no watchdog wake occurs.
- R6: `ext_rst_i` in any state moves to FRST. `full_rst_o` is 1 for one cycle, the counter is cleared, and both flags keep their values.
- R7: In HALT, a high-to-low transition on `port_i[k]` with `port_wake_en_i[k]`=1 gives `resume_o` for one cycle, then RUN. Rising edges and edges on disabled pins leave the block in HALT. The edge is acted on three clock edges after the pin changes.
- R8: The counter has 2^WDT_W states. When it is at its maximum and a count event occurs, `wdt_ovf_o` pulses and the counter wraps to 0. An overflow in RUN or HALT moves to PRST: `part_rst_o` is 1 for one cycle, `to_o` becomes 1, and `pdf_o` is unchanged.
- R9: In HALT, `irq_i` gives the same one-cycle `resume_o` and return to RUN as a port wake.
- R10: When wake sources coincide, external reset wins over watchdog overflow, and watchdog overflow wins over port edges and interrupts.
- R11: At most one of `resume_o`, `part_rst_o` and `full_rst_o` is high in any cycle. Each of them is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running tick-domain clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| halt_i | input | 1 | Halt instruction executed strobe |
| clrwdt_i | input | 1 | Clear-watchdog instruction strobe |
| ext_rst_i | input | 1 | External reset request |
| irq_i | input | 1 | Interrupt request |
| port_i | input | PORT_W | Port pin levels (asynchronous) |
| port_wake_en_i | input | PORT_W | Per-pin falling-edge wake enables |
| wdt_tick_i | input | 1 | Internal watchdog oscillator tick strobe |
| cfg_wdt_osc_en_i | input | 1 | Internal watchdog oscillator enable |
| cfg_wdt_src_sys_i | input | 1 | 1: watchdog counts on the system clock; 0: on oscillator ticks |
| sys_clk_en_o | output | 1 | System clock enable |
| pdf_o | output | 1 | Power-down flag |
| to_o | output | 1 | Watchdog time-out flag |
| resume_o | output | 1 | Continue-after-halt pulse |
| part_rst_o | output | 1 | Program counter and stack pointer reset pulse |
| full_rst_o | output | 1 | Full system reset pulse |
| wdt_clr_o | output | 1 | Watchdog counter clear |
| wdt_run_o | output | 1 | Watchdog counting permitted |
| wdt_ovf_o | output | 1 | Watchdog overflow pulse |

## Verification
The assertions take the configuration inputs as static while a halt episode runs. They also take `halt_i` to be meaningful only while the core is clocked. The stimulus changes `cfg_wdt_src_sys_i` and `cfg_wdt_osc_en_i` only in RUN, and it drives every input on the falling clock edge so that each strobe is one full cycle wide. Port edges are placed while the block sits in HALT, so each edge is seen by the synchronizer before the state machine acts on it. Coincident wake sources are lined up against the overflow cycle that the bench model predicts.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_HALT   = 3'd1,
        ST_RESUME = 3'd2,
        ST_PRST   = 3'd3,
        ST_FRST   = 3'd4
    } pd_state_e;
endpackage

// File: rtl/pdc_edge_sync.sv
module pdc_edge_sync #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_i,
    input  logic [PORT_W-1:0] en_i,
    output logic [PORT_W-1:0] fall_o,
    output logic              any_o
);
    logic [PORT_W-1:0] meta_q;
    logic [PORT_W-1:0] samp_q;
    logic [PORT_W-1:0] prev_q;

    for (genvar g = 0; g < PORT_W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[g] <= 1'b1;
                samp_q[g] <= 1'b1;
                prev_q[g] <= 1'b1;
            end else begin
                meta_q[g] <= pin_i[g];
                samp_q[g] <= meta_q[g];
                prev_q[g] <= samp_q[g];
            end
        end
        assign fall_o[g] = prev_q[g] & ~samp_q[g] & en_i[g];
    end

    assign any_o = |fall_o;
endmodule

// File: rtl/pdc_wdt.sv
module pdc_wdt #(
    parameter int WDT_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic src_sys_i,
    input  logic tick_i,
    input  logic clr_i,
    output logic ovf_o
);
    localparam logic [WDT_W-1:0] CNT_MAX = {WDT_W{1'b1}};

    logic [WDT_W-1:0] cnt_q;
    logic             step;

    assign step  = run_i & (src_sys_i | tick_i);
    assign ovf_o = step & (cnt_q == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pdc_fsm.sv
module pdc_fsm
    import pdc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      halt_i,
    input  logic      clrwdt_i,
    input  logic      ext_rst_i,
    input  logic      irq_i,
    input  logic      port_wake_i,
    input  logic      wdt_ovf_i,
    input  logic      src_sys_i,
    output pd_state_e state_o,
    output logic      sys_clk_en_o,
    output logic      resume_o,
    output logic      part_rst_o,
    output logic      full_rst_o,
    output logic      wdt_clr_o,
    output logic      pdf_o,
    output logic      to_o
);
    pd_state_e state_q;
    pd_state_e state_d;
    logic      pdf_q;
    logic      to_q;
    logic      live;
    logic      halt_ok;
    logic      clr_ok;
    logic      ovf_ok;

    assign live    = (state_q == ST_RUN) | (state_q == ST_HALT);
    assign ovf_ok  = live & ~ext_rst_i & wdt_ovf_i;
    assign halt_ok = (state_q == ST_RUN) & ~ext_rst_i & ~wdt_ovf_i & halt_i;
    assign clr_ok  = (state_q == ST_RUN) & ~ext_rst_i & ~wdt_ovf_i & ~halt_i & clrwdt_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (ext_rst_i) begin
            state_d = ST_FRST;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (wdt_ovf_i)   state_d = ST_PRST;
                    else if (halt_i) state_d = ST_HALT;
                end
                ST_HALT: begin
                    if (wdt_ovf_i)                  state_d = ST_PRST;
                    else if (port_wake_i || irq_i)  state_d = ST_RESUME;
                end
                ST_RESUME, ST_PRST, ST_FRST: state_d = ST_RUN;
                default: state_d = ST_RUN;
            endcase
        end
    end

    // outputs
    always_comb begin
        sys_clk_en_o = 1'b1;
        resume_o     = 1'b0;
        part_rst_o   = 1'b0;
        full_rst_o   = 1'b0;
        wdt_clr_o    = (halt_ok & ~src_sys_i) | clr_ok;
        unique case (state_q)
            ST_RUN:    ;
            ST_HALT:   sys_clk_en_o = 1'b0;
            ST_RESUME: resume_o     = 1'b1;
            ST_PRST:   part_rst_o   = 1'b1;
            ST_FRST: begin
                full_rst_o = 1'b1;
                wdt_clr_o  = 1'b1;
            end
            default:   ;
        endcase
    end

    // status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pdf_q <= 1'b0;
            to_q  <= 1'b0;
        end else if (ovf_ok) begin
            to_q <= 1'b1;
        end else if (halt_ok) begin
            pdf_q <= 1'b1;
            to_q  <= 1'b0;
        end else if (clr_ok) begin
            pdf_q <= 1'b0;
        end
    end

    assign state_o = state_q;
    assign pdf_o   = pdf_q;
    assign to_o    = to_q;
endmodule

// File: rtl/pwrdn_wake_ctrl.sv
module pwrdn_wake_ctrl
    import pdc_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int WDT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_i,
    input  logic              clrwdt_i,
    input  logic              ext_rst_i,
    input  logic              irq_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic [PORT_W-1:0] port_wake_en_i,
    input  logic              wdt_tick_i,
    input  logic              cfg_wdt_osc_en_i,
    input  logic              cfg_wdt_src_sys_i,
    output logic              sys_clk_en_o,
    output logic              pdf_o,
    output logic              to_o,
    output logic              resume_o,
    output logic              part_rst_o,
    output logic              full_rst_o,
    output logic              wdt_clr_o,
    output logic              wdt_run_o,
    output logic              wdt_ovf_o
);
    logic [PORT_W-1:0] port_fall;
    logic              port_wake;
    pd_state_e         state;

    pdc_edge_sync #(.PORT_W(PORT_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (port_i),
        .en_i   (port_wake_en_i),
        .fall_o (port_fall),
        .any_o  (port_wake)
    );

    assign wdt_run_o = cfg_wdt_src_sys_i ? sys_clk_en_o : cfg_wdt_osc_en_i;

    pdc_wdt #(.WDT_W(WDT_W)) u_wdt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (wdt_run_o),
        .src_sys_i (cfg_wdt_src_sys_i),
        .tick_i    (wdt_tick_i),
        .clr_i     (wdt_clr_o),
        .ovf_o     (wdt_ovf_o)
    );

    pdc_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_i       (halt_i),
        .clrwdt_i     (clrwdt_i),
        .ext_rst_i    (ext_rst_i),
        .irq_i        (irq_i),
        .port_wake_i  (port_wake),
        .wdt_ovf_i    (wdt_ovf_o),
        .src_sys_i    (cfg_wdt_src_sys_i),
        .state_o      (state),
        .sys_clk_en_o (sys_clk_en_o),
        .resume_o     (resume_o),
        .part_rst_o   (part_rst_o),
        .full_rst_o   (full_rst_o),
        .wdt_clr_o    (wdt_clr_o),
        .pdf_o        (pdf_o),
        .to_o         (to_o)
    );
endmodule

// File: rtl/pwrdn_wake_chk.sv
module pwrdn_wake_chk (
    input logic clk,
    input logic rst_n,
    input logic ext_rst_i,
    input logic irq_i,
    input logic cfg_wdt_src_sys_i,
    input logic port_wake,
    input logic sys_clk_en_o,
    input logic pdf_o,
    input logic to_o,
    input logic resume_o,
    input logic part_rst_o,
    input logic full_rst_o,
    input logic wdt_run_o,
    input logic wdt_ovf_o
);
    // R1
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_clk_en_o && !ext_rst_i && !wdt_ovf_o && !port_wake && !irq_i) |=> !sys_clk_en_o);

    // R2
    halt_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_clk_en_o) |-> (pdf_o && !to_o));

    // R4
    sys_src_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_clk_en_o && cfg_wdt_src_sys_i) |-> !wdt_run_o);

    // R6
    ext_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_i |=> full_rst_o);

    // R7
    port_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_clk_en_o && port_wake && !ext_rst_i && !wdt_ovf_o) |=> resume_o);

    // R8
    ovf_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_ovf_o && !ext_rst_i && (!sys_clk_en_o || !(resume_o || part_rst_o || full_rst_o)))
        |=> (part_rst_o && to_o));

    // R8
    ovf_pdf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_ovf_o && !ext_rst_i) |=> (pdf_o == $past(pdf_o)));

    // R11
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resume_o, part_rst_o, full_rst_o}));

    // R11
    resume_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_o && !ext_rst_i) |=> !resume_o);
endmodule

bind pwrdn_wake_ctrl pwrdn_wake_chk u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .ext_rst_i         (ext_rst_i),
    .irq_i             (irq_i),
    .cfg_wdt_src_sys_i (cfg_wdt_src_sys_i),
    .port_wake         (port_wake),
    .sys_clk_en_o      (sys_clk_en_o),
    .pdf_o             (pdf_o),
    .to_o              (to_o),
    .resume_o          (resume_o),
    .part_rst_o        (part_rst_o),
    .full_rst_o        (full_rst_o),
    .wdt_run_o         (wdt_run_o),
    .wdt_ovf_o         (wdt_ovf_o)
);

// File: tb/test_pwrdn_wake_ctrl.sv
module test_pwrdn_wake_ctrl;
    localparam int PW    = 8;
    localparam int WW    = 6;
    localparam int MAXC  = (1 << WW) - 1;
    localparam int M_RUN = 0, M_HALT = 1, M_RES = 2, M_PRST = 3, M_FRST = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          halt_i = 0, clrwdt_i = 0, ext_rst_i = 0, irq_i = 0;
    logic [PW-1:0] port_i = '1;
    logic [PW-1:0] port_wake_en_i = 8'h09;
    logic          wdt_tick_i = 0, cfg_wdt_osc_en_i = 1, cfg_wdt_src_sys_i = 0;
    logic          sys_clk_en_o, pdf_o, to_o, resume_o, part_rst_o, full_rst_o;
    logic          wdt_clr_o, wdt_run_o, wdt_ovf_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int cyc_no = 0;
    bit tick_all = 0;

    int           m_mode = M_RUN;
    int           m_cnt  = 0;
    bit           m_pdf  = 0;
    bit           m_to   = 0;
    logic [PW-1:0] hist[$];

    always #5 clk = ~clk;

    pwrdn_wake_ctrl #(.PORT_W(PW), .WDT_W(WW)) i_pwrdn_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .clrwdt_i(clrwdt_i),
        .ext_rst_i(ext_rst_i), .irq_i(irq_i), .port_i(port_i),
        .port_wake_en_i(port_wake_en_i), .wdt_tick_i(wdt_tick_i),
        .cfg_wdt_osc_en_i(cfg_wdt_osc_en_i), .cfg_wdt_src_sys_i(cfg_wdt_src_sys_i),
        .sys_clk_en_o(sys_clk_en_o), .pdf_o(pdf_o), .to_o(to_o),
        .resume_o(resume_o), .part_rst_o(part_rst_o), .full_rst_o(full_rst_o),
        .wdt_clr_o(wdt_clr_o), .wdt_run_o(wdt_run_o), .wdt_ovf_o(wdt_ovf_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc_no, act, exp);
        end
    endtask

    function automatic bit m_fall();
        return |(hist[2] & ~hist[1] & port_wake_en_i);
    endfunction

    // one cycle: compare against the model, then advance the model at the edge
    task automatic cyc();
        bit e_sys, e_run, ev, e_ovf, e_clr, run_ok;
        int nm;
        wdt_tick_i = tick_all ? 1'b1 : ((cyc_no % 4) == 0);
        #1;
        e_sys  = (m_mode != M_HALT);
        e_run  = cfg_wdt_src_sys_i ? e_sys : cfg_wdt_osc_en_i;
        ev     = e_run && (cfg_wdt_src_sys_i || wdt_tick_i);
        e_ovf  = ev && (m_cnt == MAXC);
        run_ok = (m_mode == M_RUN) && !ext_rst_i;
        e_clr  = (m_mode == M_FRST) || (run_ok && !e_ovf && halt_i && !cfg_wdt_src_sys_i)
                 || (run_ok && !e_ovf && !halt_i && clrwdt_i);
        chk(sys_clk_en_o == e_sys, "R1 sys_clk_en", sys_clk_en_o, e_sys);
        chk(pdf_o == m_pdf, "R2 pdf", pdf_o, m_pdf);
        chk(to_o == m_to, "R8 to", to_o, m_to);
        chk(resume_o == (m_mode == M_RES), "R7 resume", resume_o, m_mode == M_RES);
        chk(part_rst_o == (m_mode == M_PRST), "R8 part_rst", part_rst_o, m_mode == M_PRST);
        chk(full_rst_o == (m_mode == M_FRST), "R6 full_rst", full_rst_o, m_mode == M_FRST);
        chk(wdt_run_o == e_run, "R5 wdt_run", wdt_run_o, e_run);
        chk(wdt_clr_o == e_clr, "R4 wdt_clr", wdt_clr_o, e_clr);
        chk(wdt_ovf_o == e_ovf, "R8 wdt_ovf", wdt_ovf_o, e_ovf);
        nm = m_mode;
        if (ext_rst_i) nm = M_FRST;
        else if (m_mode == M_RUN) begin
            if (e_ovf) nm = M_PRST; else if (halt_i) nm = M_HALT;
        end else if (m_mode == M_HALT) begin
            if (e_ovf) nm = M_PRST; else if (m_fall() || irq_i) nm = M_RES;
        end else nm = M_RUN;
        if (!ext_rst_i && (m_mode == M_RUN || m_mode == M_HALT) && e_ovf) m_to = 1;
        else if (run_ok && halt_i) begin m_pdf = 1; m_to = 0; end
        else if (run_ok && clrwdt_i) m_pdf = 0;
        @(posedge clk);
        if (e_clr) m_cnt = 0;
        else if (ev) m_cnt = (m_cnt == MAXC) ? 0 : m_cnt + 1;
        m_mode = nm;
        hist.push_front(port_i);
        void'(hist.pop_back());
        cyc_no++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic pulse_halt();
        halt_i = 1; cyc(); halt_i = 0;
    endtask

    initial begin
        for (int i = 0; i < 3; i++) hist.push_back('1);
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R3 power-on clears flags; R1 starts clocked
        chk(pdf_o == 0 && to_o == 0, "R3 reset flags", {pdf_o, to_o}, 0);
        chk(sys_clk_en_o == 1, "R1 reset clk_en", sys_clk_en_o, 1);
        idle(5);
        clrwdt_i = 1; cyc(); clrwdt_i = 0;

        // R1 R2 halt entry; R7 disabled-pin and rising edges ignored
        pulse_halt();
        idle(3);
        chk(sys_clk_en_o == 0, "R1 halted", sys_clk_en_o, 0);
        chk(pdf_o == 1 && to_o == 0, "R2 flags after halt", {pdf_o, to_o}, 2);
        port_i[1] = 0; idle(5); port_i[1] = 1; idle(5);
        chk(sys_clk_en_o == 0, "R7 disabled pin ignored", sys_clk_en_o, 0);
        port_i[3] = 0; idle(2);
        chk(resume_o == 0, "R7 edge latency", resume_o, 0);
        cyc();
        chk(resume_o == 1, "R7 port wake", resume_o, 1);
        cyc();
        chk(resume_o == 0 && sys_clk_en_o == 1, "R11 single pulse", resume_o, 0);
        port_i[3] = 1; idle(4);

        // R3 clear-watchdog clears PDF
        clrwdt_i = 1; cyc(); clrwdt_i = 0;
        chk(pdf_o == 0, "R3 clrwdt clears pdf", pdf_o, 0);

        // R9 interrupt wake
        pulse_halt(); idle(4);
        irq_i = 1; cyc(); irq_i = 0;
        chk(resume_o == 1, "R9 irq wake", resume_o, 1);
        idle(3);

        // R8 watchdog wake during halt with internal source
        pulse_halt(); tick_all = 1;
        while (m_mode == M_HALT) cyc();
        chk(part_rst_o == 1 && to_o == 1 && pdf_o == 1, "R8 wdt wake", {part_rst_o, to_o, pdf_o}, 7);
        tick_all = 0; idle(3);

        // R4 system-clock source freezes counter in halt
        cfg_wdt_src_sys_i = 1; clrwdt_i = 1; cyc(); clrwdt_i = 0;
        pulse_halt(); idle(150);
        chk(sys_clk_en_o == 0 && wdt_run_o == 0, "R4 frozen", wdt_run_o, 0);
        // R6 external reset, flags kept
        ext_rst_i = 1; cyc(); ext_rst_i = 0;
        chk(full_rst_o == 1 && pdf_o == 1, "R6 full reset", {full_rst_o, pdf_o}, 3);
        idle(2);

        // R5 oscillator disabled: no watchdog wake
        cfg_wdt_src_sys_i = 0; cfg_wdt_osc_en_i = 0; idle(2);
        pulse_halt(); tick_all = 1; idle(150);
        chk(sys_clk_en_o == 0 && wdt_ovf_o == 0, "R5 no wdt wake", sys_clk_en_o, 0);
        tick_all = 0;
        irq_i = 1; cyc(); irq_i = 0; idle(2);
        cfg_wdt_osc_en_i = 1; idle(2);

        // R10 external reset beats irq and port edge
        pulse_halt(); idle(2);
        port_i[0] = 0; idle(2);
        ext_rst_i = 1; irq_i = 1; cyc(); ext_rst_i = 0; irq_i = 0;
        chk(full_rst_o == 1 && resume_o == 0, "R10 ext first", full_rst_o, 1);
        port_i[0] = 1; idle(4);

        // R10 overflow beats interrupt
        clrwdt_i = 1; cyc(); clrwdt_i = 0;
        pulse_halt(); tick_all = 1;
        while (m_cnt != MAXC) cyc();
        irq_i = 1; cyc(); irq_i = 0;
        chk(part_rst_o == 1 && resume_o == 0, "R10 ovf over irq", part_rst_o, 1);
        tick_all = 0; idle(4);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule